// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the cycle-control front end of a pipelined synchronous burst SRAM, built around a small internal word array. On every rising clock it looks at three chip enables and two active-low address strobes. One strobe is the processor-side path and the other is the controller-side path. It also samples an advance input, a sleep input and the write-enable group: a global write enable, a byte-write enable and one enable per byte lane. From these it classifies the cycle as one of six kinds: sleep, deselect, burst start, burst continue, burst suspend or idle. It then picks the address for the cycle from the external pins, the current burst address or the next burst address, and either writes the array or starts a read.

Read data leaves through a one-stage output pipeline. The data bus is modelled as a data output plus a drive qualifier. The qualifier acts as the tri-state control and depends combinationally on the output enable, so the bus reacts without waiting for a clock. Writes never turn the bus on. A high sleep input overrides every other input.

Top module: `burst_sram_ctl`

## Requirements
- R1: While `sleep` is high the block ignores every other input. No array write takes place and `d_drive` is low. Any read in flight is discarded, so after `sleep` falls the bus stays undriven until a new read has passed through the pipeline.
- R2: A strobe edge with any chip enable inactive is a deselect. Inactive means `ce_a_n`=1, `ce_b`=0 or `ce_c_n`=1. A deselect performs no access and ends the burst, and `d_drive` is low from the second clock after it.
- R3: A cycle with `strb_cpu_n` low and the chip enabled is always a read of the external address, whatever the write enables show. `strb_cpu_n` takes priority over `strb_ctl_n`.
- R4: A cycle with `strb_ctl_n` low (and `strb_cpu_n` high) and the chip enabled starts a burst at the external address. It writes when the write qualifier is true and reads otherwise.
- R5: Byte lane k is bits [9k+8:9k] of the 36-bit word. The lane is written when `gwe_n`=0, or when `bwe_n`=0 and `lane_we_n[k]`=0. The write qualifier is true when at least one lane is written.
- R6: With both strobes high, `adv_n` low and a burst active, the cycle uses the next address. The two low address bits step by +1 modulo 4 and the upper bits are held. The cycle reads or writes per the qualifier.
- R7: With both strobes high, `adv_n` high and a burst active, the cycle reuses the current address and reads or writes per the qualifier.
- R8: A read registered on clock N shows the array word on `d_out` after clock N+1, qualified by `d_drive`, for one cycle per read. A write on clock N+1 to the same address is not visible in that word.
- R9: `d_drive` is low whenever `oe_n` is high, and it follows `oe_n` without a clock edge.
- R10: `d_drive` is low during any cycle whose current inputs decode to a write.
- R11: With both strobes high and no burst active, nothing is read or written.
- R12: After synchronous reset (`rst_n` low at a clock), `d_drive` is low, no burst is active and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Power-down request, overrides all other inputs |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, always a read |
| strb_ctl_n | input | 1 | Controller-side address strobe, read or write |
| adv_n | input | 1 | Low: advance burst; high: suspend |
| gwe_n | input | 1 | Global write enable, all lanes |
| bwe_n | input | 1 | Byte-write enable, gates `lane_we_n` |
| lane_we_n | input | 4 | Per-lane write enables |
| addr | input | 6 | External word address |
| d_in | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_out | output | 36 | Read data |
| d_drive | output | 1 | Bus drive qualifier (low = tri-state) |

## Verification
The main function is exercised with write bursts through the controller-side strobe that advance past the fourth beat, so wrap-around of the low bits is separated from carry into the upper bits. Read bursts through the processor-side strobe with every write enable asserted show that this path never writes. Suspend cycles show the address is reused and not advanced. Masked writes with lanes 0 and 2 only, and with the byte-write enable low but no lane enabled, separate the lane decode from the global enable. Deselects on each chip enable, sleep cycles carrying write stimulus, and mid-cycle toggles of the output enable show which stimulus leaves the array and the bus untouched.

// File: rtl/bsram_pkg.sv
// Package: shared types for the burst SRAM cycle controller.
// Assumes: one cycle kind and one address source are chosen per clock.
package bsram_pkg;

    // Cycle kind decided from the sampled control inputs.
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_SLEEP = 3'd1,
        OP_DESEL = 3'd2,
        OP_READ  = 3'd3,
        OP_WRITE = 3'd4
    } op_e;

    // Where the address of the cycle comes from.
    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_CUR  = 2'd1,
        SRC_NEXT = 2'd2
    } src_e;

    typedef struct packed {
        op_e  op;
        src_e src;
    } cyc_t;

endpackage

// File: rtl/bsram_decode.sv
// Module: bsram_decode
// Classifies the current clock's inputs into a cycle kind and an address
// source, and produces the per-lane write mask.
// Assumes: sleep outranks the processor strobe, which outranks the
// controller strobe, which outranks advance/suspend.
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sleep,
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             active,
    output cyc_t             cyc,
    output logic [LANES-1:0] lane_mask
);

    logic chip_on;
    logic wr_qual;

    // Chip is selected only when every enable is at its active level.
    assign chip_on = ~ce_a_n & ce_b & ~ce_c_n;

    // Per-lane enable: global write, or byte-write gated by the lane bit.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = ~gwe_n | (~bwe_n & ~lane_we_n[g]);
    end

    // Qualifier is true when any lane would be written.
    assign wr_qual = |lane_mask;

    // Priority decode of the cycle kind and address source.
    always_comb begin
        cyc.op  = OP_IDLE;
        cyc.src = SRC_CUR;
        if (sleep) begin
            cyc.op = OP_SLEEP;
        end else if (!strb_cpu_n) begin
            if (!chip_on) begin
                cyc.op = OP_DESEL;
            end else begin
                cyc.op  = OP_READ;
                cyc.src = SRC_EXT;
            end
        end else if (!strb_ctl_n) begin
            if (!chip_on) begin
                cyc.op = OP_DESEL;
            end else begin
                cyc.op  = wr_qual ? OP_WRITE : OP_READ;
                cyc.src = SRC_EXT;
            end
        end else if (active) begin
            cyc.op  = wr_qual ? OP_WRITE : OP_READ;
            cyc.src = adv_n ? SRC_CUR : SRC_NEXT;
        end
    end

endmodule

// File: rtl/bsram_burst.sv
// Module: bsram_burst
// Holds the current burst address and the burst-active flag, and selects
// the effective address of the cycle.
// Assumes: only the low BEAT_W bits count inside a burst; they wrap.
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_t              cyc,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

    logic [BEAT_W-1:0] beat_nx;

    // Next beat: step the low bits, wrapping inside the group.
    assign beat_nx = cur_addr[BEAT_W-1:0] + BEAT_ONE;

    // Address mux for the current cycle.
    always_comb begin
        unique case (cyc.src)
            SRC_EXT:  eff_addr = ext_addr;
            SRC_NEXT: eff_addr = {cur_addr[ADDR_W-1:BEAT_W], beat_nx};
            default:  eff_addr = cur_addr;
        endcase
    end

    // Track the burst address and whether a burst is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            active   <= 1'b0;
        end else begin
            unique case (cyc.op)
                OP_READ, OP_WRITE: begin
                    cur_addr <= eff_addr;
                    active   <= 1'b1;
                end
                OP_DESEL: active <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bsram_store.sv
// Module: bsram_store
// Word array split into byte lanes; each lane has its own write enable.
// Assumes: synchronous write, combinational read, cleared by reset.
module bsram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Clear on reset, otherwise write this lane when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && lane_mask[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/bsram_rdpipe.sv
// Module: bsram_rdpipe
// Registers the read address, then the read word one clock later, and
// forms the asynchronous bus drive qualifier.
// Assumes: sleep flushes the pipeline; write cycles mask the bus.
module bsram_rdpipe
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_t              cyc,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] rdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] d_out,
    output logic              d_drive
);

    logic rd_pend;
    logic d_valid;

    // Two-stage read pipeline: address stage then data stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_addr <= '0;
            d_valid <= 1'b0;
            d_out   <= '0;
        end else if (cyc.op == OP_SLEEP) begin
            rd_pend <= 1'b0;
            d_valid <= 1'b0;
        end else begin
            d_valid <= rd_pend;
            d_out   <= rdata;
            rd_pend <= (cyc.op == OP_READ);
            if (cyc.op == OP_READ) rd_addr <= eff_addr;
        end
    end

    // Drive only valid read data, with OE low, outside sleep and writes.
    assign d_drive = d_valid & ~oe_n & ~sleep & (cyc.op != OP_WRITE);

endmodule

// File: rtl/burst_sram_ctl.sv
// Module: burst_sram_ctl (top)
// Cycle controller and array of a pipelined synchronous burst SRAM.
// Assumes: one clock domain, synchronous active-low reset, the data bus
// split into d_in / d_out with d_drive as the tri-state control.
module burst_sram_ctl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int BEAT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    gwe_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] d_in,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] d_out,
    output logic                    d_drive
);

    localparam int DATA_W = LANES * LANE_W;

    cyc_t              cyc;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rdata;
    logic              active;
    logic              wr_en;

    // Array write strobe for the current cycle.
    assign wr_en = (cyc.op == OP_WRITE);

    bsram_decode #(.LANES(LANES)) u_decode (
        .sleep      (sleep),
        .ce_a_n     (ce_a_n),
        .ce_b       (ce_b),
        .ce_c_n     (ce_c_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .gwe_n      (gwe_n),
        .bwe_n      (bwe_n),
        .lane_we_n  (lane_we_n),
        .active     (active),
        .cyc        (cyc),
        .lane_mask  (lane_mask)
    );

    bsram_burst #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .ext_addr (addr),
        .eff_addr (eff_addr),
        .cur_addr (cur_addr),
        .active   (active)
    );

    bsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .lane_mask (lane_mask),
        .waddr     (eff_addr),
        .wdata     (d_in),
        .raddr     (rd_addr),
        .rdata     (rdata)
    );

    bsram_rdpipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .eff_addr (eff_addr),
        .rdata    (rdata),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .rd_addr  (rd_addr),
        .d_out    (d_out),
        .d_drive  (d_drive)
    );

endmodule

// File: rtl/bsram_ctl_chk.sv
// Module: bsram_ctl_chk
// Property checker for burst_sram_ctl, attached by bind below.
// Assumes: it observes the top's ports plus wr_en, active and cur_addr.
module bsram_ctl_chk #(
    parameter int ADDR_W = 6,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              strb_cpu_n,
    input logic              strb_ctl_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              d_drive,
    input logic              wr_en,
    input logic              active,
    input logic [ADDR_W-1:0] cur_addr
);

    logic chip_off;
    logic no_strobe;

    assign chip_off  = ce_a_n | ~ce_b | ce_c_n;
    assign no_strobe = strb_cpu_n & strb_ctl_n;

    assert_sleep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!d_drive && !wr_en));

    assert_desel_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !no_strobe && chip_off) |=> !active);

    assert_cpu_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_cpu_n) |-> !wr_en);

    assert_wrap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && no_strobe && !adv_n && active) |=>
        ((cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + 1'b1) &&
         (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]))));

    assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && no_strobe && adv_n) |=> $stable(cur_addr));

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !d_drive);

    assert_write_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !d_drive);

    assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !active) |-> !wr_en);

endmodule

bind burst_sram_ctl bsram_ctl_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_sram_ctl_bench.sv
// Bench: drives burst_sram_ctl on the falling edge and compares the bus
// against a behavioural model on every clock.
module burst_sram_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep, ce_a_n, ce_b, ce_c_n;
    logic          strb_cpu_n, strb_ctl_n, adv_n, gwe_n, bwe_n, oe_n;
    logic [NL-1:0] lane_we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in;
    logic [DW-1:0] d_out;
    logic          d_drive;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // Model state
    logic [DW-1:0] mm [64];
    int            m_cur;
    bit            m_act, m_rpend, m_dval;
    int            m_raddr;
    logic [DW-1:0] m_dq;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram_ctl u_burst_sram_ctl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_a_n(ce_a_n), .ce_b(ce_b),
        .ce_c_n(ce_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
        .addr(addr), .d_in(d_in), .oe_n(oe_n), .d_out(d_out), .d_drive(d_drive)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
            summary();
            $finish;
        end
    end

    function automatic bit chip_on();
        return !ce_a_n && ce_b && !ce_c_n;
    endfunction

    function automatic logic [DW-1:0] lane_bits();
        logic [DW-1:0] m;
        for (int k = 0; k < NL; k++)
            m[k*LW +: LW] = (!gwe_n || (!bwe_n && !lane_we_n[k])) ? '1 : '0;
        return m;
    endfunction

    function automatic bit qual();
        return lane_bits() != '0;
    endfunction

    // Does the present input set decode to a write?
    function automatic bit write_now();
        if (sleep || !strb_cpu_n) return 0;
        if (!strb_ctl_n) return chip_on() && qual();
        return m_act && qual();
    endfunction

    // Model update for one rising edge.
    task automatic model_edge();
        int ea;
        bit rd, wr;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mm[i] = '0;
            m_cur = 0; m_act = 0; m_rpend = 0; m_dval = 0; m_raddr = 0; m_dq = '0;
            return;
        end
        if (sleep) begin
            m_rpend = 0; m_dval = 0;
            return;
        end
        m_dval = m_rpend;
        m_dq   = mm[m_raddr];
        rd = 0; wr = 0; ea = m_cur;
        if (!strb_cpu_n || !strb_ctl_n) begin
            if (!chip_on()) begin
                m_act = 0;
            end else begin
                ea = addr;
                if (!strb_cpu_n) rd = 1;
                else if (qual()) wr = 1;
                else rd = 1;
            end
        end else if (m_act) begin
            if (!adv_n) ea = (m_cur & ~3) | ((m_cur + 1) % 4);
            if (qual()) wr = 1; else rd = 1;
        end
        m_rpend = rd;
        if (rd) m_raddr = ea;
        if (rd || wr) begin m_cur = ea; m_act = 1; end
        if (wr) mm[ea] = (mm[ea] & ~lane_bits()) | (d_in & lane_bits());
    endtask

    task automatic check_bus(input string tag);
        bit exp_drv;
        exp_drv = m_dval && !oe_n && !sleep && !write_now();
        vectors++;
        if (d_drive !== exp_drv) begin
            fails++;
            $display("FAIL %s d_drive: actual %b expected %b", tag, d_drive, exp_drv);
        end
        if (exp_drv) begin
            vectors++;
            if (d_out !== m_dq) begin
                fails++;
                $display("FAIL %s d_out: actual %h expected %h", tag, d_out, m_dq);
            end
        end
    endtask

    task automatic step(input string tag);
        #1 check_bus(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic set_idle();
        sleep = 0; ce_a_n = 0; ce_b = 1; ce_c_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        gwe_n = 1; bwe_n = 1; lane_we_n = '1; oe_n = 0;
        addr = '0; d_in = '0;
    endtask

    task automatic cpu_read(input int a);
        set_idle(); strb_cpu_n = 0; addr = AW'(a);
    endtask

    initial begin
        set_idle();
        rst_n = 0;
        @(negedge clk);
        repeat (3) step("R12");
        rst_n = 1;
        step("R12");

        // R11: advance/write with no open burst does nothing
        adv_n = 0; gwe_n = 0; d_in = '1;
        step("R11"); step("R11");
        cpu_read(1); step("R12");
        set_idle(); step("R8"); step("R12");

        // R4/R6/R7: controller-side write burst at 4, wraps, then suspends
        set_idle(); strb_ctl_n = 0; addr = 4; gwe_n = 0; d_in = 36'h1_1111_1111;
        step("R4");
        strb_ctl_n = 1; adv_n = 0;
        d_in = 36'h2_2222_2222; step("R6");
        d_in = 36'h3_3333_3333; step("R6");
        d_in = 36'h4_4444_4444; step("R6");
        d_in = 36'h5_5555_5555; step("R6");
        adv_n = 1; d_in = 36'h6_6666_6666; step("R7");

        // R3: processor strobe reads even with all write enables low
        cpu_read(6); gwe_n = 0; bwe_n = 0; lane_we_n = '0; d_in = 36'hF_0F0F_0F0F;
        step("R3");
        set_idle(); adv_n = 0;
        step("R8"); step("R6"); step("R6");
        adv_n = 1; step("R7"); step("R7");

        // R9: output enable acts without a clock
        oe_n = 1; #2 check_bus("R9");
        oe_n = 0; #1 check_bus("R9");
        @(negedge clk);
        step("R9");

        // R10: write immediately after a read masks the bus
        cpu_read(5); step("R8");
        set_idle(); strb_ctl_n = 0; addr = 12; gwe_n = 0; d_in = 36'h7_7777_7777;
        step("R10");
        set_idle(); step("R10");

        // R5: byte lanes 0 and 2 only
        set_idle(); strb_ctl_n = 0; addr = 9; bwe_n = 0; lane_we_n = 4'b1010;
        d_in = 36'hA_BCDE_F012; step("R5");
        // R5: byte-write enable low, no lane: a read
        set_idle(); strb_ctl_n = 0; addr = 9; bwe_n = 0; lane_we_n = 4'b1111;
        d_in = 36'h9_9999_9999; step("R5");
        // R5: lanes low but byte-write enable high: a read
        set_idle(); strb_ctl_n = 0; addr = 12; lane_we_n = 4'b0000;
        d_in = 36'h8_8888_8888; step("R5");
        set_idle(); step("R5"); step("R5");

        // R2: deselect on each chip enable
        cpu_read(20); ce_b = 0; step("R2");
        set_idle(); adv_n = 0; gwe_n = 0; d_in = 36'h1_2121_2121; step("R2");
        set_idle(); strb_ctl_n = 0; ce_c_n = 1; addr = 20; gwe_n = 0;
        d_in = 36'h2_3232_3232; step("R2");
        set_idle(); strb_ctl_n = 0; ce_a_n = 1; addr = 21; gwe_n = 0;
        d_in = 36'h3_4343_4343; step("R2");
        set_idle(); step("R2");
        cpu_read(20); step("R2");
        cpu_read(21); step("R2");
        set_idle(); step("R2"); step("R2");

        // R1: sleep ignores a write and flushes a read in flight
        cpu_read(4); step("R1");
        set_idle(); sleep = 1; strb_ctl_n = 0; addr = 4; gwe_n = 0;
        d_in = 36'hD_EADB_EEF0;
        step("R1"); step("R1");
        strb_ctl_n = 1; adv_n = 0; step("R1");
        set_idle(); step("R1"); step("R1");
        cpu_read(4); step("R1");
        set_idle(); step("R1"); step("R1");

        // R8: back-to-back reads give one word per clock
        cpu_read(8); step("R8");
        cpu_read(9); step("R8");
        cpu_read(12); step("R8");
        set_idle(); step("R8"); step("R8");

        summary();
        $finish;
    end

endmodule